// File: doc/BRIEF.md
# Saturating Output Watchdog

This block guards a set of actuator outputs against a host that has stopped talking. It keeps a small up-counter and a one-bit arming flag. A host write with the refresh bit set arrives as a single-cycle refresh strobe. The strobe clears the counter and arms the watchdog. The counter has no timebase of its own. It advances once for every overflow of a free-running PWM period counter, which arrives as a single-cycle tick. The counter stops at its largest value.

When the watchdog is armed and the counter has reached its largest value, the block raises an output-disable signal. The surrounding logic uses this signal to put the dedicated digital outputs and the PWM outputs into high impedance. The default width is 7 bits, which gives 127 ticks of about 51.2 µs each, roughly 6.5 ms. Only reset disarms the watchdog. No host action can turn it off again once it is armed. Register decoding and the PWM generator sit outside the block.

Top module: `output_watchdog`

## Requirements
- R1: After reset the watchdog is disarmed and `out_disable_o` is 0. While it is disarmed, any number of ticks leaves `out_disable_o` at 0.
- R2: After a refresh, `out_disable_o` stays 0 through the first 2^CNT_W−2 ticks. It becomes 1 right after the clock edge that samples tick number 2^CNT_W−1 (127 at the default width).
- R3: The counter saturates. Further ticks after the timeout keep `out_disable_o` at 1, and it stays 1 until a refresh or a reset.
- R4: A refresh sampled while `out_disable_o` is 1 brings it to 0 on that same clock edge. A fresh full count of ticks is then needed before it rises again.
- R5: When a refresh and a tick are sampled in the same cycle, the refresh takes priority. The counter ends at 0, so 2^CNT_W−1 further ticks are needed for a timeout.
- R6: A refresh never disarms the watchdog. Once armed, it times out again after every later run of 2^CNT_W−1 unrefreshed ticks.
- R7: Cycles without a tick do not advance the counter. Idle cycles placed between ticks do not change how many ticks are needed for a timeout.
- R8: Synchronous active-high reset disarms the watchdog and clears the counter. After reset, `out_disable_o` is 0 and stays 0 under ticks alone, even if the block had timed out before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_i | input | 1 | Single-cycle refresh strobe: clears the counter and arms the watchdog |
| tick_i | input | 1 | Single-cycle PWM period overflow event |
| out_disable_o | output | 1 | 1 = tristate the guarded outputs |

## Verification
The assertions take `kick_i` and `tick_i` to be 0/1 values that are synchronous to `clk` and valid at every sampled edge. They also take reset to be applied before the first checked cycle. The properties follow the counter and the arming flag from the edge after reset onward.

The bench meets these conditions by driving both strobes only from tasks, one time unit after a rising edge. It pulses each strobe for exactly one cycle and holds reset for two cycles at the start. The sweeps cover every tick count from 0 to two beyond the timeout, with both dense and sparse tick spacing.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned WDG_CNT_W_DEFAULT = 7;

    // Action the counter takes in a given cycle; refresh outranks a tick.
    typedef enum logic [1:0] {
        WDG_HOLD  = 2'd0,
        WDG_ADV   = 2'd1,
        WDG_CLEAR = 2'd2
    } wdg_cmd_e;

    function automatic wdg_cmd_e wdg_decode(input logic kick, input logic tick);
        if (kick)      return WDG_CLEAR;
        else if (tick) return WDG_ADV;
        else           return WDG_HOLD;
    endfunction

endpackage

// File: rtl/wdg_arm_flag.sv
module wdg_arm_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    output logic armed_o
);
    // Sticky: only reset returns it to 0.
    always_ff @(posedge clk) begin
        if (rst)        armed_o <= 1'b0;
        else if (set_i) armed_o <= 1'b1;
    end
endmodule

// File: rtl/wdg_sat_counter.sv
module wdg_sat_counter
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W = WDG_CNT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  wdg_cmd_e         cmd_i,
    output logic [CNT_W-1:0] count_o,
    output logic             at_max_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assign at_max_o = (count_o == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
        end else begin
            unique case (cmd_i)
                WDG_CLEAR: count_o <= '0;
                WDG_ADV:   if (!at_max_o) count_o <= count_o + CNT_ONE;
                default:   count_o <= count_o;
            endcase
        end
    end
endmodule

// File: rtl/output_watchdog.sv
module output_watchdog
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W = WDG_CNT_W_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    input  logic tick_i,
    output logic out_disable_o
);
    wdg_cmd_e         cmd;
    logic             armed_q;
    logic [CNT_W-1:0] count_q;
    logic             at_max;

    assign cmd = wdg_decode(kick_i, tick_i);

    wdg_arm_flag u_arm (
        .clk     (clk),
        .rst     (rst),
        .set_i   (kick_i),
        .armed_o (armed_q)
    );

    wdg_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .count_o  (count_q),
        .at_max_o (at_max)
    );

    assign out_disable_o = armed_q && at_max;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             kick_i,
    input logic             tick_i,
    input logic             out_disable_o,
    input logic             armed,
    input logic [CNT_W-1:0] count
);
    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !out_disable_o); // R1

    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(out_disable_o) |-> ($past(tick_i) && !$past(kick_i))); // R2

    AST_HOLD_UNTIL_REFRESH: assert property (@(posedge clk) disable iff (rst)
        (out_disable_o && !kick_i) |=> out_disable_o); // R3

    AST_REFRESH_RELEASES: assert property (@(posedge clk) disable iff (rst)
        kick_i |=> !out_disable_o); // R4

    AST_REFRESH_WINS: assert property (@(posedge clk) disable iff (rst)
        (kick_i && tick_i) |=> (count == '0)); // R5

    AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!kick_i && !tick_i) |=> $stable(count)); // R7
endmodule

bind output_watchdog wdg_checker #(.CNT_W(CNT_W)) u_wdg_chk (
    .clk           (clk),
    .rst           (rst),
    .kick_i        (kick_i),
    .tick_i        (tick_i),
    .out_disable_o (out_disable_o),
    .armed         (armed_q),
    .count         (count_q)
);

// File: tb/tb_output_watchdog.sv
`timescale 1ns/1ps
module tb_output_watchdog;
    localparam int CNT_W = 7;
    localparam int TMO   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic kick_i = 1'b0;
    logic tick_i = 1'b0;
    logic out_disable_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    output_watchdog #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .kick_i(kick_i), .tick_i(tick_i),
        .out_disable_o(out_disable_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<190000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // One clock: inputs applied 1 ns after an edge, output read 1 ns after the next.
    task automatic step(input logic k, input logic t);
        kick_i = k;
        tick_i = t;
        @(posedge clk);
        #1;
        kick_i = 1'b0;
        tick_i = 1'b0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b1);
            for (int g = 0; g < gap; g++) step(1'b0, 1'b0);
        end
    endtask

    task automatic check(input logic exp, input string tag);
        n_cmp++;
        if (out_disable_o !== exp) begin
            n_bad++;
            $display("FAIL %s: out_disable_o actual=%b expected=%b", tag, out_disable_o, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        #1;
        do_reset();
        check(1'b0, "R1 reset state");

        // R1: disarmed, ticks never disable
        ticks(TMO + 20, 0);
        check(1'b0, "R1 ticks while disarmed");

        // R2/R3: exhaustive sweep of tick counts after a refresh, dense spacing
        for (int n = 0; n <= TMO + 2; n++) begin
            step(1'b1, 1'b0);
            check(1'b0, "R4 refresh releases");
            ticks(n, 0);
            check((n >= TMO) ? 1'b1 : 1'b0, (n > TMO) ? "R3 saturate" : "R2 timeout count");
        end

        // R3: held high with no refresh over idle and more ticks
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
        check(1'b1, "R3 holds while idle");
        ticks(50, 0);
        check(1'b1, "R3 holds under ticks");

        // R7: sparse spacing, gaps of 1..3 idle cycles
        for (int gap = 1; gap <= 3; gap++) begin
            step(1'b1, 1'b0);
            ticks(TMO - 1, gap);
            check(1'b0, "R7 sparse one short");
            ticks(1, gap);
            check(1'b1, "R7 sparse timeout");
        end

        // R5: refresh and tick together, from timed-out and mid-count states
        step(1'b1, 1'b1);
        check(1'b0, "R5 simultaneous releases");
        ticks(TMO - 1, 0);
        check(1'b0, "R5 counter was cleared");
        ticks(1, 0);
        check(1'b1, "R5 full count after clear");
        step(1'b1, 1'b0);
        ticks(60, 0);
        step(1'b1, 1'b1);
        ticks(TMO - 1, 0);
        check(1'b0, "R5 mid-count clear");
        ticks(1, 0);
        check(1'b1, "R5 mid-count timeout");

        // R6: repeated refreshes never disarm
        for (int r = 0; r < 3; r++) begin
            step(1'b1, 1'b0);
            step(1'b1, 1'b0);
            ticks(TMO, 0);
            check(1'b1, "R6 re-timeout after refresh");
        end

        // R8: reset after timeout disarms
        do_reset();
        check(1'b0, "R8 reset clears disable");
        ticks(TMO + 30, 0);
        check(1'b0, "R8 disarmed after reset");
        step(1'b1, 1'b0);
        ticks(TMO, 0);
        check(1'b1, "R8 rearm after reset");

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule